// File: doc/BRIEF.md
# Security-Banked Cache and TLB Control Registers

This block holds three system control registers that a processor reaches through a coprocessor move-to / move-from port. Each access strobe carries the four selector fields (opcode1, CRn, CRm, opcode2), a write flag, write data, the security world of the access (non-secure flag) and the privilege level. The block answers one cycle later with registered read data and an undefined-instruction flag.

The first register selects which bank of tightly-coupled-memory configuration is in use. It is kept as one copy per security world, and the copy of the current world is exported as the active bank index. The second register forces write-through and disables instruction or data linefill, separately for secure and non-secure regions. Its secure half is hidden from the non-secure world. The block merges this register with debug-state controls into effective override outputs. The third register steers hardware table-walk results into a numbered lockdown entry of the TLB. Non-secure access to it is allowed only while an external TL control bit is set.

Top module: `sec_ctl_regs`

## Requirements
- R1: After reset, both bank-select copies, the six override bits, the victim index and the placement bit are all 0, and `undef_o` is 0.
- R2: Decode: opcode1=0, CRn=9, CRm=2, opcode2=0 selects bank select; opcode1=0, CRn=9, CRm=8, opcode2=0 selects the override register; opcode1=0, CRn=10, CRm=0, opcode2=0 selects TLB lockdown. Any other combination raises `undef_o` and returns read data 0.
- R3: Any access with `priv_i`=0 raises `undef_o` and changes no register.
- R4: Bank select is held in bits [1:0] as one copy per world. An access uses, and `tcm_bank_o` shows, the copy of the world given by `ns_i`.
- R5: A write of 2 or 3 to bank select is discarded. A write of 1 is also discarded when `NUM_TCM`=1.
- R6: Override layout: bit 5 forces write-through, bit 4 disables instruction linefill, bit 3 disables data linefill, all for secure regions. Bits 2, 1 and 0 carry the same controls for non-secure regions. A secure write updates all six bits.
- R7: A non-secure read of the override register returns 0 in bits [5:3]. A non-secure write leaves bits [5:3] unchanged and updates bits [2:0].
- R8: When `dbg_i`=1, `ovr_o` takes {wt,il,dl} from the debug inputs for both halves. When `dbg_i`=0, `ovr_o` equals the override register.
- R9: TLB lockdown holds the victim index in bits [28:26] and the placement bit in bit 0. Both are exported on `tlb_victim_o` and `tlb_place_o`.
- R10: A non-secure privileged access to TLB lockdown raises `undef_o` and changes nothing when `tl_i`=0. It is allowed when `tl_i`=1.
- R11: `rdata_o` and `undef_o` are registered and valid in the cycle after the strobe. `undef_o` is 0 after a cycle without a strobe. Write data in reserved bits is ignored, and reserved bits read as 0. A write returns read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_vld_i | input | 1 | Access strobe |
| acc_wr_i | input | 1 | 1 = write (move-to), 0 = read |
| op1_i | input | 3 | Opcode1 selector |
| crn_i | input | 4 | CRn selector |
| crm_i | input | 4 | CRm selector |
| op2_i | input | 3 | Opcode2 selector |
| wdata_i | input | DATA_W | Write data |
| ns_i | input | 1 | Access is from the non-secure world |
| priv_i | input | 1 | Access is privileged |
| tl_i | input | 1 | Non-secure TLB lockdown access enable |
| dbg_i | input | 1 | Core is in debug state |
| dbg_wt_i | input | 1 | Debug force write-through |
| dbg_il_i | input | 1 | Debug instruction linefill disable |
| dbg_dl_i | input | 1 | Debug data linefill disable |
| rdata_o | output | DATA_W | Registered read data |
| undef_o | output | 1 | Registered undefined-instruction flag |
| tcm_bank_o | output | 2 | Active bank index for the world on `ns_i` |
| ovr_o | output | 6 | Effective overrides, same bit layout as R6 |
| tlb_victim_o | output | 3 | Lockdown victim index |
| tlb_place_o | output | 1 | Place walk results in the lockdown region |

## Verification
Read data and the undefined flag are due one clock edge after the strobe. The bench drives each access on a falling edge, holds it through one rising edge and samples both at the next falling edge. A write becomes visible at that same edge, so the state outputs (`tcm_bank_o`, `ovr_o`, victim, placement) are compared against the bench model at that sample point as well. `ovr_o` and `tcm_bank_o` also depend combinationally on `dbg_i` and `ns_i`, so after changing only those inputs the bench waits a fraction of a cycle before it samples.

// File: rtl/sec_ctl_pkg.sv
package sec_ctl_pkg;
  typedef enum logic [1:0] {REG_NONE, REG_TCM, REG_CBO, REG_TLB} reg_sel_e;

  localparam int SEL_W   = 2;   // bank-select field width
  localparam int CBO_W   = 6;   // override field width
  localparam int CBO_HI  = 3;   // lowest secure-only override bit
  localparam int VIC_W   = 3;
  localparam int VIC_LSB = 26;
  localparam int P_BIT   = 0;

  localparam logic [3:0] CRN_C9  = 4'd9;
  localparam logic [3:0] CRN_C10 = 4'd10;
  localparam logic [3:0] CRM_TCM = 4'd2;
  localparam logic [3:0] CRM_CBO = 4'd8;
  localparam logic [3:0] CRM_TLB = 4'd0;
endpackage

// File: rtl/sec_ctl_decode.sv
module sec_ctl_decode
  import sec_ctl_pkg::*;
(
  input  logic [2:0] op1_i,
  input  logic [3:0] crn_i,
  input  logic [3:0] crm_i,
  input  logic [2:0] op2_i,
  input  logic       ns_i,
  input  logic       priv_i,
  input  logic       tl_i,
  output reg_sel_e   sel_o,
  output logic       undef_o
);
  logic base_ok;
  assign base_ok = (op1_i == 3'd0) && (op2_i == 3'd0);

  always_comb begin
    sel_o = REG_NONE;
    if (base_ok && crn_i == CRN_C9 && crm_i == CRM_TCM)       sel_o = REG_TCM;
    else if (base_ok && crn_i == CRN_C9 && crm_i == CRM_CBO)  sel_o = REG_CBO;
    else if (base_ok && crn_i == CRN_C10 && crm_i == CRM_TLB) sel_o = REG_TLB;
  end

  assign undef_o = !priv_i || (sel_o == REG_NONE) ||
                   (sel_o == REG_TLB && ns_i && !tl_i);
endmodule

// File: rtl/tcm_sel_bank.sv
module tcm_sel_bank
  import sec_ctl_pkg::*;
#(
  parameter int NUM_TCM = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             ns_i,
  input  logic [SEL_W-1:0] wsel_i,
  output logic [SEL_W-1:0] sel_s_o,
  output logic [SEL_W-1:0] sel_ns_o,
  output logic [SEL_W-1:0] bank_o
);
  localparam int NWORLD = 2;
  logic [SEL_W-1:0] copy_q [NWORLD];
  logic             in_range;

  assign in_range = 32'(wsel_i) < NUM_TCM;

  for (genvar w = 0; w < NWORLD; w++) begin : g_world
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) copy_q[w] <= '0;
      else if (we_i && in_range && (ns_i == (w == 1))) copy_q[w] <= wsel_i;
    end
  end

  assign sel_s_o  = copy_q[0];
  assign sel_ns_o = copy_q[1];
  assign bank_o   = ns_i ? copy_q[1] : copy_q[0];
endmodule

// File: rtl/cache_ovr_reg.sv
module cache_ovr_reg
  import sec_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             ns_i,
  input  logic [CBO_W-1:0] wdata_i,
  input  logic             dbg_i,
  input  logic             dbg_wt_i,
  input  logic             dbg_il_i,
  input  logic             dbg_dl_i,
  output logic [CBO_W-1:0] cbo_o,
  output logic [CBO_W-1:0] eff_o
);
  logic [CBO_W-1:0] cbo_q;
  logic [CBO_W-1:0] wmask;

  // non-secure writers reach only the common half
  assign wmask = ns_i ? CBO_W'((1 << CBO_HI) - 1) : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cbo_q <= '0;
    else if (we_i) cbo_q <= (cbo_q & ~wmask) | (wdata_i & wmask);
  end

  assign cbo_o = cbo_q;
  assign eff_o = dbg_i ? {2{dbg_wt_i, dbg_il_i, dbg_dl_i}} : cbo_q;
endmodule

// File: rtl/tlb_lock_reg.sv
module tlb_lock_reg
  import sec_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [VIC_W-1:0] victim_i,
  input  logic             place_i,
  output logic [VIC_W-1:0] victim_o,
  output logic             place_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      victim_o <= '0;
      place_o  <= 1'b0;
    end else if (we_i) begin
      victim_o <= victim_i;
      place_o  <= place_i;
    end
  end
endmodule

// File: rtl/sec_ctl_regs.sv
module sec_ctl_regs
  import sec_ctl_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_TCM = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_vld_i,
  input  logic              acc_wr_i,
  input  logic [2:0]        op1_i,
  input  logic [3:0]        crn_i,
  input  logic [3:0]        crm_i,
  input  logic [2:0]        op2_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ns_i,
  input  logic              priv_i,
  input  logic              tl_i,
  input  logic              dbg_i,
  input  logic              dbg_wt_i,
  input  logic              dbg_il_i,
  input  logic              dbg_dl_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              undef_o,
  output logic [SEL_W-1:0]  tcm_bank_o,
  output logic [CBO_W-1:0]  ovr_o,
  output logic [VIC_W-1:0]  tlb_victim_o,
  output logic              tlb_place_o
);
  reg_sel_e         acc_sel;
  logic             acc_undef, acc_ok, wr_ok;
  logic [SEL_W-1:0] tcm_sel_s, tcm_sel_ns;
  logic [CBO_W-1:0] cbo_q;
  logic [DATA_W-1:0] rd_val;

  sec_ctl_decode u_dec (
    .op1_i, .crn_i, .crm_i, .op2_i, .ns_i, .priv_i, .tl_i,
    .sel_o(acc_sel), .undef_o(acc_undef)
  );

  assign acc_ok = acc_vld_i && !acc_undef;
  assign wr_ok  = acc_ok && acc_wr_i;

  tcm_sel_bank #(.NUM_TCM(NUM_TCM)) u_tcm (
    .clk_i, .rst_ni,
    .we_i    (wr_ok && acc_sel == REG_TCM),
    .ns_i,
    .wsel_i  (wdata_i[SEL_W-1:0]),
    .sel_s_o (tcm_sel_s),
    .sel_ns_o(tcm_sel_ns),
    .bank_o  (tcm_bank_o)
  );

  cache_ovr_reg u_cbo (
    .clk_i, .rst_ni,
    .we_i   (wr_ok && acc_sel == REG_CBO),
    .ns_i,
    .wdata_i(wdata_i[CBO_W-1:0]),
    .dbg_i, .dbg_wt_i, .dbg_il_i, .dbg_dl_i,
    .cbo_o  (cbo_q),
    .eff_o  (ovr_o)
  );

  tlb_lock_reg u_tlb (
    .clk_i, .rst_ni,
    .we_i    (wr_ok && acc_sel == REG_TLB),
    .victim_i(wdata_i[VIC_LSB +: VIC_W]),
    .place_i (wdata_i[P_BIT]),
    .victim_o(tlb_victim_o),
    .place_o (tlb_place_o)
  );

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[DATA_W-1:VIC_LSB+VIC_W],
                          wdata_i[VIC_LSB-1:CBO_W]};

  always_comb begin
    rd_val = '0;
    unique case (acc_sel)
      REG_TCM: rd_val[SEL_W-1:0] = ns_i ? tcm_sel_ns : tcm_sel_s;
      REG_CBO: begin
        rd_val[CBO_HI-1:0] = cbo_q[CBO_HI-1:0];
        if (!ns_i) rd_val[CBO_W-1:CBO_HI] = cbo_q[CBO_W-1:CBO_HI];
      end
      REG_TLB: begin
        rd_val[VIC_LSB +: VIC_W] = tlb_victim_o;
        rd_val[P_BIT]            = tlb_place_o;
      end
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      undef_o <= 1'b0;
    end else begin
      undef_o <= acc_vld_i && acc_undef;
      if (acc_vld_i) rdata_o <= (acc_ok && !acc_wr_i) ? rd_val : '0;
    end
  end
endmodule

// File: rtl/sec_ctl_regs_chk.sv
module sec_ctl_regs_chk
  import sec_ctl_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_TCM = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_vld_i,
  input logic              acc_wr_i,
  input logic [2:0]        op1_i,
  input logic [3:0]        crn_i,
  input logic [3:0]        crm_i,
  input logic [2:0]        op2_i,
  input logic              ns_i,
  input logic              priv_i,
  input logic              tl_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              undef_o,
  input logic [SEL_W-1:0]  tcm_sel_s,
  input logic [SEL_W-1:0]  tcm_sel_ns,
  input logic [CBO_W-1:0]  cbo_q,
  input logic [VIC_W-1:0]  tlb_victim_o,
  input logic              tlb_place_o
);
  logic zero_ops, is_tcm, is_cbo, is_tlb;
  assign zero_ops = op1_i == 3'd0 && op2_i == 3'd0;
  assign is_tcm = zero_ops && crn_i == 4'd9  && crm_i == 4'd2;
  assign is_cbo = zero_ops && crn_i == 4'd9  && crm_i == 4'd8;
  assign is_tlb = zero_ops && crn_i == 4'd10 && crm_i == 4'd0;

  p_unmatched_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_vld_i && !(is_tcm || is_cbo || is_tlb) |=> undef_o && rdata_o == '0);

  p_user_undef_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_vld_i && !priv_i |=> undef_o);

  p_user_nostate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_vld_i && !priv_i |=> $stable(cbo_q) && $stable(tcm_sel_s) &&
      $stable(tcm_sel_ns) && $stable(tlb_victim_o) && $stable(tlb_place_o));

  p_world_copy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_vld_i && ns_i |=> $stable(tcm_sel_s));

  p_bank_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(tcm_sel_s) < NUM_TCM && 32'(tcm_sel_ns) < NUM_TCM);

  p_ns_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_vld_i && ns_i && is_cbo |=> $stable(cbo_q[CBO_W-1:CBO_HI]));

  p_ns_rdzero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_vld_i && !acc_wr_i && ns_i && is_cbo |=> rdata_o[CBO_W-1:CBO_HI] == '0);

  p_tl_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_vld_i && priv_i && ns_i && !tl_i && is_tlb |=>
      undef_o && $stable(tlb_victim_o) && $stable(tlb_place_o));

  p_undef_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_vld_i |=> !undef_o);

  p_reserved_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_vld_i && !acc_wr_i && is_tlb |=>
      rdata_o[VIC_LSB-1:1] == '0 && rdata_o[DATA_W-1:VIC_LSB+VIC_W] == '0);
endmodule

bind sec_ctl_regs sec_ctl_regs_chk #(.DATA_W(DATA_W), .NUM_TCM(NUM_TCM)) u_chk (
  .clk_i, .rst_ni, .acc_vld_i, .acc_wr_i, .op1_i, .crn_i, .crm_i, .op2_i,
  .ns_i, .priv_i, .tl_i, .rdata_o, .undef_o, .tcm_sel_s, .tcm_sel_ns,
  .cbo_q, .tlb_victim_o, .tlb_place_o
);

// File: tb/tb_sec_ctl_regs.sv
`timescale 1ns/1ps
module tb_sec_ctl_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_vld = 0, acc_wr = 0, ns = 0, priv = 1, tl = 0;
  logic dbg = 0, dbg_wt = 0, dbg_il = 0, dbg_dl = 0;
  logic [2:0] op1 = 0, op2 = 0;
  logic [3:0] crn = 0, crm = 0;
  logic [31:0] wdata = 0;

  logic [31:0] rdata, rdata1;
  logic undef, undef1, place, place1;
  logic [1:0] bank, bank1;
  logic [5:0] ovr, ovr1;
  logic [2:0] vic, vic1;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  logic [1:0] m_sel [2];
  logic [1:0] m1_sel [2];
  logic [5:0] m_cbo;
  logic [2:0] m_vic;
  logic       m_p;

  always #2.5 clk = ~clk;

  sec_ctl_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .acc_vld_i(acc_vld), .acc_wr_i(acc_wr),
    .op1_i(op1), .crn_i(crn), .crm_i(crm), .op2_i(op2), .wdata_i(wdata),
    .ns_i(ns), .priv_i(priv), .tl_i(tl), .dbg_i(dbg), .dbg_wt_i(dbg_wt),
    .dbg_il_i(dbg_il), .dbg_dl_i(dbg_dl), .rdata_o(rdata), .undef_o(undef),
    .tcm_bank_o(bank), .ovr_o(ovr), .tlb_victim_o(vic), .tlb_place_o(place)
  );

  sec_ctl_regs #(.NUM_TCM(1)) dut_one (
    .clk_i(clk), .rst_ni(rst_n), .acc_vld_i(acc_vld), .acc_wr_i(acc_wr),
    .op1_i(op1), .crn_i(crn), .crm_i(crm), .op2_i(op2), .wdata_i(wdata),
    .ns_i(ns), .priv_i(priv), .tl_i(tl), .dbg_i(dbg), .dbg_wt_i(dbg_wt),
    .dbg_il_i(dbg_il), .dbg_dl_i(dbg_dl), .rdata_o(rdata1), .undef_o(undef1),
    .tcm_bank_o(bank1), .ovr_o(ovr1), .tlb_victim_o(vic1), .tlb_place_o(place1)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    logic [5:0] e_ovr;
    e_ovr = dbg ? {2{dbg_wt, dbg_il, dbg_dl}} : m_cbo;
    chk(bank == m_sel[ns], {tag, " R4 bank"}, 32'(bank), 32'(m_sel[ns]));
    chk(bank1 == m1_sel[ns], {tag, " R5 bank one-tcm"}, 32'(bank1), 32'(m1_sel[ns]));
    chk(ovr == e_ovr, {tag, " R8 ovr"}, 32'(ovr), 32'(e_ovr));
    chk({vic, place} == {m_vic, m_p}, {tag, " R9 tlb out"},
        32'({vic, place}), 32'({m_vic, m_p}));
  endtask

  // one access; rdata/undef sampled at the falling edge after the capturing edge
  task automatic do_acc(input logic wr, input logic a_ns, input logic a_priv,
                        input logic [2:0] o1, input logic [3:0] n,
                        input logic [3:0] m, input logic [2:0] o2,
                        input logic [31:0] wd, input string tag);
    bit is_tcm, is_cbo, is_tlb, e_undef;
    logic [31:0] e_rd;
    is_tcm = o1 == 0 && o2 == 0 && n == 9  && m == 2;
    is_cbo = o1 == 0 && o2 == 0 && n == 9  && m == 8;
    is_tlb = o1 == 0 && o2 == 0 && n == 10 && m == 0;
    e_undef = !a_priv || !(is_tcm || is_cbo || is_tlb) || (is_tlb && a_ns && !tl);
    e_rd = '0;
    if (!wr && !e_undef) begin
      if (is_tcm) e_rd = 32'(m_sel[a_ns]);
      if (is_cbo) e_rd = a_ns ? 32'(m_cbo[2:0]) : 32'(m_cbo);
      if (is_tlb) e_rd = (32'(m_vic) << 26) | 32'(m_p);
    end
    @(negedge clk);
    acc_vld = 1; acc_wr = wr; ns = a_ns; priv = a_priv;
    op1 = o1; crn = n; crm = m; op2 = o2; wdata = wd;
    @(negedge clk);
    acc_vld = 0;
    if (wr && !e_undef) begin
      if (is_tcm) begin
        if (wd[1:0] < 2) m_sel[a_ns] = wd[1:0];
        if (wd[1:0] < 1) m1_sel[a_ns] = wd[1:0];
      end
      if (is_cbo) begin
        if (a_ns) m_cbo[2:0] = wd[2:0];
        else m_cbo = wd[5:0];
      end
      if (is_tlb) begin
        m_vic = wd[28:26];
        m_p = wd[0];
      end
    end
    chk(undef == e_undef, {tag, " R11 undef"}, 32'(undef), 32'(e_undef));
    chk(rdata == e_rd, {tag, " R11 rdata"}, rdata, e_rd);
    check_state(tag);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_sel[0] = 0; m_sel[1] = 0; m1_sel[0] = 0; m1_sel[1] = 0;
    m_cbo = 0; m_vic = 0; m_p = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(undef == 0, "R1 undef at reset", 32'(undef), 0);
    chk(rdata == 0, "R1 rdata at reset", rdata, 0);
    check_state("R1 reset");

    // R2 decode sweep (reads only)
    for (int o1 = 0; o1 < 2; o1++)
      for (int n = 0; n < 16; n++)
        for (int m = 0; m < 16; m++)
          for (int o2 = 0; o2 < 2; o2++)
            do_acc(0, 0, 1, 3'(o1), 4'(n), 4'(m), 3'(o2), 0, "R2 decode");

    // R4/R5 bank select, every value from each world
    for (int w = 0; w < 2; w++)
      for (int v = 0; v < 4; v++) begin
        do_acc(1, w[0], 1, 0, 9, 2, 0, 32'hFFFF_FFFC | 32'(v), "R5 tcm write");
        do_acc(0, 0, 1, 0, 9, 2, 0, 0, "R4 tcm read s");
        do_acc(0, 1, 1, 0, 9, 2, 0, 0, "R4 tcm read ns");
      end
    do_acc(1, 0, 1, 0, 9, 2, 0, 1, "R4 tcm set s");
    do_acc(1, 1, 1, 0, 9, 2, 0, 0, "R4 tcm set ns");
    do_acc(0, 0, 1, 0, 9, 2, 0, 0, "R4 tcm s kept");

    // R6/R7 override register, all values from both worlds
    for (int w = 0; w < 2; w++)
      for (int v = 0; v < 64; v++) begin
        do_acc(1, w[0], 1, 0, 9, 8, 0, 32'hFFFF_FFC0 | 32'(v), "R6 cbo write");
        do_acc(0, 0, 1, 0, 9, 8, 0, 0, "R6 cbo read s");
        do_acc(0, 1, 1, 0, 9, 8, 0, 0, "R7 cbo read ns");
      end
    do_acc(1, 0, 1, 0, 9, 8, 0, 32'h38, "R6 cbo secure set");
    do_acc(1, 1, 1, 0, 9, 8, 0, 32'h05, "R7 cbo ns write");
    do_acc(0, 0, 1, 0, 9, 8, 0, 0, "R7 secure half kept");

    // R9/R10/R11 TLB lockdown with TL and world sweep, reserved bits set
    for (int t = 0; t < 2; t++)
      for (int w = 0; w < 2; w++)
        for (int v = 0; v < 16; v++) begin
          tl = t[0];
          do_acc(1, w[0], 1, 0, 10, 0, 0,
                 32'hE3FF_FFFE | (32'(v >> 1) << 26) | 32'(v & 1), "R10 tlb write");
          do_acc(0, w[0], 1, 0, 10, 0, 0, 0, "R9 tlb read");
        end

    // R3 user-mode access to every register from both worlds
    for (int w = 0; w < 2; w++) begin
      do_acc(1, w[0], 0, 0, 9, 2, 0, 0, "R3 user tcm");
      do_acc(1, w[0], 0, 0, 9, 8, 0, 32'h0, "R3 user cbo");
      do_acc(1, w[0], 0, 0, 10, 0, 0, 32'h0, "R3 user tlb");
      do_acc(0, w[0], 0, 0, 9, 8, 0, 0, "R3 user read");
    end

    // R8 debug precedence
    dbg = 1;
    for (int d = 0; d < 8; d++) begin
      {dbg_wt, dbg_il, dbg_dl} = 3'(d);
      #1;
      check_state("R8 debug");
    end
    dbg = 0;
    #1;
    check_state("R8 functional");

    // R11 no strobe -> undef low
    do_acc(0, 0, 0, 0, 9, 2, 0, 0, "R11 undef set");
    @(negedge clk);
    chk(undef == 0, "R11 undef pulse clears", 32'(undef), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule